// File: doc/BRIEF.md
# Clock Generator Configuration Register Slave (two-wire serial)

This block is the serial configuration front end of a clock generator. It watches an open-drain two-wire serial bus (I2C, standard mode, 100 kbit/s or slower), oversampled by a fast system clock, and keeps seven byte-wide control registers that the core logic of the clock generator uses directly: one frequency and mode byte, followed by output-enable bytes in which a 1 turns an output on and a 0 holds it off.

Writes use a block-write form. After the address come two header bytes, a command code and then a byte count. Both are acknowledged and thrown away. The data bytes that follow land in register 0, register 1 and so on upward, with no register addressing. The host may stop after any complete byte. Reads also carry no address. The slave first returns a byte count of 6 and then registers 0 to 5. Some bits of the read-back show strap inputs that are latched elsewhere, so software can see which hardware frequency selection is in force.

Top module: `clkcfg_i2c_slave`

## Requirements
- R1: The slave acknowledges the 7-bit address 0x69, which is 0xD2 on the wire for a write and 0xD3 for a read. Any other address is not acknowledged, and the rest of that transfer leaves every register and SDA untouched.
- R2: In a write, the first two bytes after the address (command code, then byte count) are acknowledged and change no register.
- R3: Data bytes after the two header bytes are acknowledged and stored into registers 0, 1, 2 ... in that order. After a stop, the registers already written keep their new values and all others keep their old ones.
- R4: Data bytes beyond register 5 are acknowledged but have no effect. Register 6 is never changed by a write and always holds 0x06.
- R5: A read returns 0x06 as the first byte, then registers 0 to 5 while the host acknowledges. Any byte after that reads 0xFF.
- R6: Strap bits are read-only. On read-back, register 1 bits [7:5] show strap_i[2:0], register 4 bit 2 shows strap_i[3] and register 4 bit 4 shows strap_i[4]. On regs_o these stored bits are always 0, and writes to them are ignored. Writable masks are 0xFF for registers 0, 2, 3 and 5, 0x1F for register 1, 0xEB for register 4 and 0x00 for register 6.
- R7: Synchronous active-high reset loads registers 0 to 6 with 0x00, 0x1F, 0xFF, 0xFF, 0x6B, 0xFF, 0x06 (regs_o bits [8k+7:8k] carry register k) and releases SDA.
- R8: When the host does not acknowledge a read byte, the slave releases SDA and stays silent until the next start condition.
- R9: A start condition in any state, including a repeated start with no stop before it, restarts the address phase.
- R10: The slave starts pulling SDA low only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the pad |
| sda_i | input | 1 | Serial data line as seen on the pad |
| strap_i | input | STRAP_W (5) | Latched strap levels, read back through registers 1 and 4 |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| regs_o | output | NUM_REGS*8 (56) | Stored register bytes, register k at bits [8k+7:8k] |

## Verification
A wrong byte index or a bad write mask shows on regs_o within a few system clocks of the falling SCL edge that ends the data byte. It is caught on the first bus-idle cycle after the stop, because the stored bytes are compared every cycle against a reference model. A shift register or state machine that has lost its place shows up as a missing or extra acknowledge, or as a wrong read byte, within one byte time (nine SCL periods). The checks after a host NACK and after an unknown address catch an output enable that stays stuck on.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_WRITE,
    ST_SEND,
    ST_HOST_ACK,
    ST_RELOAD,
    ST_WAIT_STOP
  } bus_state_t;

  // Power-on value of each register byte.
  function automatic logic [7:0] reg_default(input int idx);
    case (idx)
      1:       return 8'h1F;
      2, 3, 5: return 8'hFF;
      4:       return 8'h6B;
      6:       return 8'h06;
      default: return 8'h00;
    endcase
  endfunction

  // Bits that a bus write may change; the rest keep their value.
  function automatic logic [7:0] reg_wmask(input int idx);
    case (idx)
      0, 2, 3, 5: return 8'hFF;
      1:          return 8'h1F;
      4:          return 8'hEB;
      default:    return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/cc_line_sync.sv
module cc_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_prev, sda_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
      scl_prev <= scl_pipe[SYNC_STAGES-1];
      sda_prev <= sda_pipe[SYNC_STAGES-1];
    end
  end

  assign scl_lvl   = scl_pipe[SYNC_STAGES-1];
  assign sda_lvl   = sda_pipe[SYNC_STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_prev;
  assign scl_fall  = ~scl_lvl & scl_prev;
  assign start_evt = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_evt  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

endmodule

// File: rtl/cc_bus_fsm.sv
module cc_bus_fsm
  import clkcfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         IDX_W    = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_lvl,
  input  logic             sda_lvl,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_evt,
  input  logic             stop_evt,
  input  logic [7:0]       rd_data,
  output logic             sda_oe,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_data,
  output logic [IDX_W-1:0] rd_idx
);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;
  localparam logic [IDX_W-1:0] HDR_LEN = IDX_W'(2);

  bus_state_t       state;
  logic [7:0]       shreg;
  logic [7:0]       tx;
  logic [3:0]       bit_cnt;
  logic             rw;
  logic [IDX_W-1:0] byte_cnt;

  assign rd_idx = byte_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      shreg    <= '0;
      tx       <= '0;
      bit_cnt  <= '0;
      rw       <= 1'b0;
      byte_cnt <= '0;
      sda_oe   <= 1'b0;
      wr_en    <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_evt) begin
        state   <= ST_ADDR;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
      end else if (stop_evt) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_WRITE: begin
            if (scl_rise && bit_cnt != 4'd8) begin
              shreg   <= {shreg[6:0], sda_lvl};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
              bit_cnt <= '0;
              if (state == ST_ADDR) begin
                if (shreg[7:1] == DEV_ADDR) begin
                  rw       <= shreg[0];
                  sda_oe   <= 1'b1;
                  byte_cnt <= '0;
                  state    <= ST_ACK;
                end else begin
                  state <= ST_WAIT_STOP;
                end
              end else begin
                sda_oe <= 1'b1;
                state  <= ST_ACK;
                if (byte_cnt >= HDR_LEN) begin
                  wr_en   <= 1'b1;
                  wr_idx  <= byte_cnt - HDR_LEN;
                  wr_data <= shreg;
                end
                if (byte_cnt != IDX_MAX) byte_cnt <= byte_cnt + IDX_W'(1);
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              if (rw) begin
                tx       <= rd_data;
                sda_oe   <= ~rd_data[7];
                bit_cnt  <= '0;
                byte_cnt <= byte_cnt + IDX_W'(1);
                state    <= ST_SEND;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_WRITE;
              end
            end
          end
          ST_SEND: begin
            if (scl_fall) begin
              if (bit_cnt == 4'd7) begin
                sda_oe <= 1'b0;
                state  <= ST_HOST_ACK;
              end else begin
                bit_cnt <= bit_cnt + 4'd1;
                tx      <= {tx[6:0], 1'b0};
                sda_oe  <= ~tx[6];
              end
            end
          end
          ST_HOST_ACK: begin
            if (scl_rise) state <= sda_lvl ? ST_WAIT_STOP : ST_RELOAD;
          end
          ST_RELOAD: begin
            if (scl_fall) begin
              tx      <= rd_data;
              sda_oe  <= ~rd_data[7];
              bit_cnt <= '0;
              if (byte_cnt != IDX_MAX) byte_cnt <= byte_cnt + IDX_W'(1);
              state   <= ST_SEND;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R10
  sda_low_only_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_lvl);

  // R8
  silent_after_nack_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT_STOP) |-> !sda_oe);

  // R3
  write_acked_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> sda_oe);

  // R2
  write_only_in_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (!rw && state == ST_ACK));

endmodule

// File: rtl/cc_reg_bank.sv
module cc_reg_bank
  import clkcfg_pkg::*;
#(
  parameter int NUM_REGS = 7,
  parameter int NUM_READ = 6,
  parameter int STRAP_W  = 5,
  parameter int IDX_W    = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [7:0]            wr_data,
  input  logic [IDX_W-1:0]      rd_idx,
  input  logic [STRAP_W-1:0]    strap_i,
  output logic [7:0]            rd_data,
  output logic [NUM_REGS*8-1:0] regs_o
);
  logic [7:0] regs_q [NUM_REGS];
  logic [7:0] view   [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [7:0] DEF  = reg_default(g);
    localparam logic [7:0] MASK = reg_wmask(g);
    always_ff @(posedge clk) begin
      if (rst)
        regs_q[g] <= DEF;
      else if (wr_en && wr_idx == IDX_W'(g))
        regs_q[g] <= (regs_q[g] & ~MASK) | (wr_data & MASK);
    end
    assign regs_o[8*g +: 8] = regs_q[g];
  end

  // Read-back view: strap levels replace the read-only bits.
  always_comb begin
    for (int k = 0; k < NUM_REGS; k++) view[k] = regs_q[k];
    view[1][7:5] = strap_i[2:0];
    view[4][2]   = strap_i[3];
    view[4][4]   = strap_i[4];
  end

  always_comb begin
    rd_data = 8'hFF;
    if (rd_idx == '0) rd_data = 8'(NUM_READ);
    for (int k = 0; k < NUM_READ; k++)
      if (rd_idx == IDX_W'(k + 1)) rd_data = view[k];
  end

  // R4
  locked_tail_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx >= IDX_W'(NUM_REGS - 1)) |=> $stable(regs_o));

  // R6
  strap_bits_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (regs_q[1][7:5] == 3'b000) && !regs_q[4][4] && !regs_q[4][2]);

endmodule

// File: rtl/clkcfg_i2c_slave.sv
module clkcfg_i2c_slave #(
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         NUM_REGS    = 7,
  parameter int         NUM_READ    = 6,
  parameter int         STRAP_W     = 5,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scl_i,
  input  logic                  sda_i,
  input  logic [STRAP_W-1:0]    strap_i,
  output logic                  sda_oe_o,
  output logic [NUM_REGS*8-1:0] regs_o
);
  localparam int IDX_W = $clog2(NUM_REGS + 3) + 1;

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [7:0]       wr_data, rd_data;

  cc_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_lvl   (scl_lvl),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  cc_bus_fsm #(.DEV_ADDR(DEV_ADDR), .IDX_W(IDX_W)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .scl_lvl   (scl_lvl),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .rd_data   (rd_data),
    .sda_oe    (sda_oe_o),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .rd_idx    (rd_idx)
  );

  cc_reg_bank #(
    .NUM_REGS (NUM_REGS),
    .NUM_READ (NUM_READ),
    .STRAP_W  (STRAP_W),
    .IDX_W    (IDX_W)
  ) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .rd_idx  (rd_idx),
    .strap_i (strap_i),
    .rd_data (rd_data),
    .regs_o  (regs_o)
  );

  // R9
  start_restarts_chk: assert property (@(posedge clk) disable iff (rst)
    start_evt |=> !sda_oe_o);

endmodule

// File: tb/test_clkcfg_i2c_slave.sv
module test_clkcfg_i2c_slave;
  typedef logic [7:0] byte_q_t [$];
  localparam int H = 25;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_scl = 1'b1;
  logic host_sda = 1'b1;
  logic [4:0] strap = 5'b10110;
  logic sda_oe;
  logic [55:0] regs;
  wire sda_line;
  assign sda_line = host_sda & ~sda_oe;

  always #2 clk = ~clk;

  clkcfg_i2c_slave i_clkcfg_i2c_slave (
    .clk(clk), .rst(rst), .scl_i(host_scl), .sda_i(sda_line),
    .strap_i(strap), .sda_oe_o(sda_oe), .regs_o(regs)
  );

  int checks = 0;
  int failures = 0;
  bit cmp_en = 1'b0;
  bit done = 1'b0;
  logic [7:0] model [7];
  logic [7:0] defs [7] = '{8'h00, 8'h1F, 8'hFF, 8'hFF, 8'h6B, 8'hFF, 8'h06};
  logic [7:0] wm   [7] = '{8'hFF, 8'h1F, 8'hFF, 8'hFF, 8'hEB, 8'hFF, 8'h00};

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // Reference model of the stored bytes, compared on every idle clock (R3, R4, R6, R7)
  always @(negedge clk) begin
    if (cmp_en) begin
      checks++;
      for (int k = 0; k < 7; k++) begin
        if (regs[8*k +: 8] !== model[k] || sda_oe !== 1'b0) begin
          failures++;
          if (failures < 20)
            $display("FAIL R3 idle regs byte %0d act=%h exp=%h oe=%b", k, regs[8*k +: 8], model[k], sda_oe);
          break;
        end
      end
    end
  end

  task automatic hold(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    host_sda = 1'b1; hold(H);
    host_scl = 1'b1; hold(H);
    host_sda = 1'b0; hold(H);
    host_scl = 1'b0; hold(H);
  endtask

  task automatic bus_stop();
    host_sda = 1'b0; hold(H);
    host_scl = 1'b1; hold(H);
    host_sda = 1'b1; hold(H);
  endtask

  task automatic bit_out(input logic b);
    host_sda = b;    hold(H);
    host_scl = 1'b1; hold(H);
    host_scl = 1'b0;
  endtask

  task automatic bit_in(output logic b);
    host_sda = 1'b1; hold(H);
    host_scl = 1'b1; hold(H / 2);
    @(negedge clk);
    b = sda_line;
    hold(H - H / 2);
    host_scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(b);
    acked = ~b;
  endtask

  task automatic recv_byte(output logic [7:0] d, input bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      bit_in(b);
      d[i] = b;
    end
    bit_out(~ack);
  endtask

  function automatic logic [7:0] exp_rd(input int k);
    logic [7:0] v;
    if (k == 0) return 8'h06;
    if (k > 6) return 8'hFF;
    v = model[k-1];
    if (k == 2) v[7:5] = strap[2:0];
    if (k == 5) begin v[2] = strap[3]; v[4] = strap[4]; end
    return v;
  endfunction

  task automatic write_tx(input byte_q_t d, input bit do_stop);
    logic a;
    cmp_en = 1'b0;
    bus_start();
    send_byte(8'hD2, a); chk(a, "R1", "write address ack", {7'd0, a}, 8'h01);
    send_byte(8'hA5, a); chk(a, "R2", "command code ack", {7'd0, a}, 8'h01);
    send_byte(8'h03, a); chk(a, "R2", "byte count ack", {7'd0, a}, 8'h01);
    foreach (d[i]) begin
      send_byte(d[i], a);
      chk(a, (i >= 6) ? "R4" : "R3", "data byte ack", {7'd0, a}, 8'h01);
      if (i < 7) model[i] = (model[i] & ~wm[i]) | (d[i] & wm[i]);
    end
    if (do_stop) begin
      bus_stop(); hold(5);
      cmp_en = 1'b1;
    end
  endtask

  task automatic read_tx(input int nb, input bit with_start);
    logic a;
    logic [7:0] v;
    cmp_en = 1'b0;
    if (with_start) bus_start();
    send_byte(8'hD3, a); chk(a, "R1", "read address ack", {7'd0, a}, 8'h01);
    for (int k = 0; k <= nb; k++) begin
      recv_byte(v, k < nb);
      chk(v == exp_rd(k), (k == 2 || k == 5) ? "R6" : "R5", "read byte", v, exp_rd(k));
    end
    hold(4);
    chk(sda_oe == 1'b0, "R8", "SDA released after NACK", {7'd0, sda_oe}, 8'h00);
    recv_byte(v, 1'b1);
    chk(v == 8'hFF, "R8", "silent byte after NACK", v, 8'hFF);
    bus_stop(); hold(5);
    cmp_en = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] v;
    hold(10);
    rst = 1'b0;
    hold(5);
    // R7 reset state
    for (int k = 0; k < 7; k++) begin
      model[k] = defs[k];
      chk(regs[8*k +: 8] == defs[k], "R7", "reset value", regs[8*k +: 8], defs[k]);
    end
    chk(sda_oe == 1'b0, "R7", "SDA released at reset", {7'd0, sda_oe}, 8'h00);
    cmp_en = 1'b1;

    // R2 header only: nothing changes
    write_tx('{}, 1'b1);
    hold(20);

    // R3 partial write of two bytes
    write_tx('{8'h12, 8'h34}, 1'b1);
    chk(regs[15:8] == 8'h14, "R6", "read-only bits of reg 1 kept clear", regs[15:8], 8'h14);
    hold(20);

    // R4 R6 full write plus overrun
    write_tx('{8'h81, 8'hFF, 8'h5A, 8'hC3, 8'hFF, 8'h3C, 8'h00, 8'h77, 8'h88}, 1'b1);
    chk(regs[55:48] == 8'h06, "R4", "register 6 locked", regs[55:48], 8'h06);
    chk(regs[39:32] == 8'hEB, "R6", "register 4 masked", regs[39:32], 8'hEB);

    // R5 full read with one byte past the end
    read_tx(7, 1'b1);

    // R6 strap change shows on read-back
    strap = 5'b01001;
    hold(10);
    read_tx(6, 1'b1);

    // R1 wrong address: no ack, nothing changes
    cmp_en = 1'b0;
    bus_start();
    send_byte(8'hA0, a); chk(!a, "R1", "foreign address not acked", {7'd0, a}, 8'h00);
    send_byte(8'h00, a); chk(!a, "R1", "byte after foreign address not acked", {7'd0, a}, 8'h00);
    bus_stop(); hold(5);
    cmp_en = 1'b1;
    hold(10);

    // R9 repeated start from write into read
    write_tx('{8'h42}, 1'b0);
    bus_start();
    read_tx(1, 1'b0);
    chk(regs[7:0] == 8'h42, "R9", "byte before repeated start kept", regs[7:0], 8'h42);

    // R7 reset restores defaults
    cmp_en = 1'b0;
    @(posedge clk); #1 rst = 1'b1;
    hold(3);
    rst = 1'b0;
    hold(2);
    for (int k = 0; k < 7; k++) model[k] = defs[k];
    chk(regs[7:0] == 8'h00 && regs[39:32] == 8'h6B, "R7", "reset after writes", regs[39:32], 8'h6B);
    cmp_en = 1'b1;
    hold(20);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule